// File: doc/BRIEF.md
# Staircased Result Frame Collector

This block sits at the output edge of a K×K multiply-accumulate grid and turns its diagonally skewed running sums into clean result rows. The grid's feed side raises `busy_i` for every cycle in which it pushes an input row. The collector delays that signal to open a collect window. During the window it emits one K-wide row per cycle, and every K rows form one K×K frame. The frame sequence restarts at each K-cycle boundary for as long as the feed lasts. A long streaming reduction therefore yields a cumulative partial-sum frame every K cycles, and the last frame holds the complete result.

The grid's timing contract is as follows. The running sum of PE(r,c) that includes feed row m appears on the PE bus during cycle m+r+c. Cycle 0 is the cycle in which `busy_i` is first high for that feed. That value is guaranteed only in that one cycle, because the next feed row is folded in one cycle later. Each output column therefore has its own sampler, which picks up its PE value at the exact cycle it is final and delays it by K−1−c cycles. All K entries of an emitted row then belong to the same frame. The sampler of the last column passes straight through without a register.

Each column sampler runs a small sequencer with three named states:
- IDLE: no window is open, and the next active cycle is row 0.
- ROW: a frame is in progress.
- BOUNDARY: the last row of a frame has just been taken, and the next active cycle is row 0 of a new frame.

The transitions are:
- start: IDLE→ROW on the first active cycle.
- advance: ROW→ROW.
- wrap: ROW→BOUNDARY after row K−1.
- continue: BOUNDARY→ROW.
- close: any state→IDLE when the column's delayed busy is low.

Top module: `stair_frame_collector`

## Requirements
- R1: `clct_valid_o` is high in cycle t+2K−2 exactly when `busy_i` was high in cycle t. It is low in every other cycle.
- R2: Whenever `clct_valid_o` is low, `row_idx_o` and `row_data_o` read all zeros.
- R3: The first valid cycle of a window carries row index 0. Each further valid cycle raises the binary index by one, and K−1 wraps to 0, which starts a new frame.
- R4: Suppose the row with index r is emitted in cycle E. Then column c of `row_data_o` (bits [c*W +: W]) equals what PE(r,c) showed in cycle E−(K−1−c). PE(r,c) sits at bits [(r*K+c)*W +: W] of `pe_res_i`. Values shown in any other cycle have no effect on that row.
- R5: The row sequence and the column alignment stay correct through a feed of 5K cycles, which wraps the row index five times.
- R6: A feed of M = nK cycles produces n frames. Given the grid contract, frame f contains the cumulative sums over feed rows 0 to fK−1, and the last frame contains the full M-row sum.
- R7: The grid may restart its accumulators at feed row K, which happens when a keep-low cycle is injected at input tick K−1. In that case frame 2 carries only the sum over rows K to 2K−1, with no carry-over from frame 1.
- R8: A single low cycle on `busy_i` closes the window. The following feed reopens it at row 0, even when the first feed ended mid-frame.
- R9: While `rst_n` is low, and right after it is released, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| busy_i | input | 1 | Feed side is pushing a row in this cycle |
| pe_res_i | input | K*K*W | Running sums of all PEs, PE(r,c) at [(r*K+c)*W +: W] |
| clct_valid_o | output | 1 | An output row is presented in this cycle |
| row_idx_o | output | $clog2(K) | Row number within the current frame |
| row_data_o | output | K*W | K result values of the row, column c at [c*W +: W] |

## Verification
The hardest situation to reach is a second feed that starts after a single idle cycle, when the first feed stopped mid-frame. In that case the left column samplers are already collecting the new feed while the right ones are still draining the old one. Every column must close and reopen its frame sequence at its own offset. The stimulus schedules such a pair, a 5K feed and a feed with a grid accumulator restart. A behavioural model of the grid drives values that are valid only in their one contracted cycle and are junk at all other times, so any sampling slip of one cycle shows up in the compared rows.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    // Per-column frame sequencer states
    typedef enum logic [1:0] {
        SQ_IDLE     = 2'd0,   // window closed, next active row is 0
        SQ_ROW      = 2'd1,   // inside a frame
        SQ_BOUNDARY = 2'd2    // last row of a frame taken, next is row 0
    } seq_state_t;

endpackage

// File: rtl/sfc_busy_line.sv
module sfc_busy_line #(
    parameter int DEPTH = 6,
    parameter int FIRST = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               busy_i,
    output logic [DEPTH:FIRST] tap_o
);

    // sh[d] holds busy_i delayed by d cycles
    logic [DEPTH:1] sh;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '0;
        end else begin
            sh <= {sh[DEPTH-1:1], busy_i};
        end
    end

    assign tap_o = sh[DEPTH:FIRST];

endmodule

// File: rtl/sfc_frame_seq.sv
module sfc_frame_seq
    import sfc_pkg::*;
#(
    parameter int K  = 4,
    parameter int RW = $clog2(K)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    output logic [RW-1:0] row_o
);

    localparam logic [RW-1:0] LAST_ROW = RW'(K - 1);

    seq_state_t    state, nxt_state;
    logic [RW-1:0] cnt, nxt_cnt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
        end
    end

    // transitions
    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        unique case (state)
            SQ_IDLE: begin
                if (en_i) begin
                    nxt_state = SQ_ROW;          // start
                    nxt_cnt   = RW'(1);
                end else begin
                    nxt_cnt   = '0;
                end
            end
            SQ_ROW: begin
                if (!en_i) begin
                    nxt_state = SQ_IDLE;         // close
                    nxt_cnt   = '0;
                end else if (cnt == LAST_ROW) begin
                    nxt_state = SQ_BOUNDARY;     // wrap
                    nxt_cnt   = '0;
                end else begin
                    nxt_state = SQ_ROW;          // advance
                    nxt_cnt   = cnt + RW'(1);
                end
            end
            SQ_BOUNDARY: begin
                if (!en_i) begin
                    nxt_state = SQ_IDLE;         // close
                    nxt_cnt   = '0;
                end else begin
                    nxt_state = SQ_ROW;          // continue
                    nxt_cnt   = RW'(1);
                end
            end
            default: begin
                nxt_state = SQ_IDLE;
                nxt_cnt   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        row_o = '0;
        if (en_i && state == SQ_ROW) begin
            row_o = cnt;
        end
    end

    // R3: after the last row of a frame comes row 0 or the window closes
    p_frame_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && row_o == LAST_ROW) |=> (!en_i || row_o == '0));

endmodule

// File: rtl/sfc_pipe.sv
module sfc_pipe #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_o = stg[DEPTH-1];

endmodule

// File: rtl/sfc_column.sv
module sfc_column #(
    parameter int K     = 4,
    parameter int W     = 16,
    parameter int DEPTH = 0,
    parameter int RW    = $clog2(K)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_i,
    input  logic [K*W-1:0] pe_col_i,
    output logic [W-1:0]   col_o,
    output logic [RW-1:0]  row_o
);

    localparam int PW = RW + W;

    logic [RW-1:0] smp_row;
    logic [W-1:0]  smp_val;
    logic [PW-1:0] smp_pack, out_pack;

    sfc_frame_seq #(.K(K), .RW(RW)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (en_i),
        .row_o (smp_row)
    );

    // pick this column's PE for the row it will present DEPTH cycles later
    always_comb begin
        smp_val = '0;
        if (en_i) begin
            smp_val = pe_col_i[int'(smp_row)*W +: W];
        end
    end

    assign smp_pack = {smp_row, smp_val};

    generate
        if (DEPTH == 0) begin : g_direct
            assign out_pack = smp_pack;
        end else begin : g_skew
            sfc_pipe #(.W(PW), .DEPTH(DEPTH)) u_skew (
                .clk   (clk),
                .rst_n (rst_n),
                .d_i   (smp_pack),
                .q_o   (out_pack)
            );
        end
    endgenerate

    assign row_o = out_pack[PW-1:W];
    assign col_o = out_pack[W-1:0];

endmodule

// File: rtl/stair_frame_collector.sv
module stair_frame_collector #(
    parameter int K = 4,
    parameter int W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    busy_i,
    input  logic [K*K*W-1:0]        pe_res_i,
    output logic                    clct_valid_o,
    output logic [$clog2(K)-1:0]    row_idx_o,
    output logic [K*W-1:0]          row_data_o
);

    localparam int RW  = $clog2(K);
    localparam int DLY = 2*K - 2;     // busy to collect-valid delay
    localparam int T0  = K - 1;       // delay at which column 0 samples

    logic [DLY:T0]  tap;
    logic [RW-1:0]  row_d [K];

    sfc_busy_line #(.DEPTH(DLY), .FIRST(T0)) u_busy (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy_i (busy_i),
        .tap_o  (tap)
    );

    generate
        for (genvar c = 0; c < K; c++) begin : g_col
            logic [K*W-1:0] pe_col;
            for (genvar r = 0; r < K; r++) begin : g_row
                assign pe_col[r*W +: W] = pe_res_i[(r*K+c)*W +: W];
            end

            sfc_column #(.K(K), .W(W), .DEPTH(K-1-c), .RW(RW)) u_col (
                .clk      (clk),
                .rst_n    (rst_n),
                .en_i     (tap[T0+c]),
                .pe_col_i (pe_col),
                .col_o    (row_data_o[c*W +: W]),
                .row_o    (row_d[c])
            );

            if (c < K-1) begin : g_chk
                // R4: every skewed column presents the same row as the last one
                p_col_agree_r4: assert property (@(posedge clk) disable iff (!rst_n)
                    clct_valid_o |-> (row_d[c] == row_idx_o));
            end
        end
    endgenerate

    assign clct_valid_o = tap[DLY];
    assign row_idx_o    = row_d[K-1];

    // R2: outputs are quiet outside the window
    p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clct_valid_o |-> (row_idx_o == '0 && row_data_o == '0));

    // R3: a window opens on row 0
    p_start_row0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clct_valid_o) |-> (row_idx_o == '0));

    // R3: rows advance by one with wrap to 0
    p_row_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clct_valid_o && $past(clct_valid_o)) |->
        (row_idx_o == (($past(row_idx_o) == RW'(K-1)) ? '0 : ($past(row_idx_o) + RW'(1)))));

endmodule

// File: tb/stair_frame_collector_bench.sv
module stair_frame_collector_bench;

    localparam int K    = 4;
    localparam int W    = 16;
    localparam int RW   = $clog2(K);
    localparam int DLY  = 2*K - 2;
    localparam int NF   = 6;
    localparam int TEND = 170;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               busy = 1'b0;
    logic [K*K*W-1:0]   pe_bus = '0;
    logic               vld;
    logic [RW-1:0]      ridx;
    logic [K*W-1:0]     rdat;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // feed schedule: start cycle, length, accumulator restart row (-1 none)
    int fs   [NF] = '{0, 30, 70, 100, 107, 135};
    int fm   [NF] = '{8, 20,  8,   6,   4,   3};
    int frst [NF] = '{-1, -1, 4,  -1,  -1,  -1};

    logic [K*K*W-1:0] pe_hist [0:TEND-1];

    always #5 clk = ~clk;

    stair_frame_collector #(.K(K), .W(W)) u_stair_frame_collector (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy_i       (busy),
        .pe_res_i     (pe_bus),
        .clct_valid_o (vld),
        .row_idx_o    (ridx),
        .row_data_o   (rdat)
    );

    function automatic int a_val(int f, int j, int r);
        return (j*3 + r*5 + f*7 + 1) % 9;
    endfunction

    function automatic int b_val(int f, int j, int c);
        return ((j*2 + c*3 + f) % 5) + 1;
    endfunction

    function automatic int seg_sum(int f, int lo, int hi, int r, int c);
        int s = 0;
        for (int j = lo; j <= hi; j++) s += a_val(f, j, r) * b_val(f, j, c);
        return s;
    endfunction

    function automatic bit busy_at(int t);
        for (int f = 0; f < NF; f++)
            if (t - fs[f] >= 0 && t - fs[f] < fm[f]) return 1'b1;
        return 1'b0;
    endfunction

    // behavioural grid: sum through row m is valid only in cycle m+r+c
    function automatic logic [W-1:0] pe_val(int r, int c, int t);
        for (int f = 0; f < NF; f++) begin
            int m = t - fs[f] - r - c;
            if (m >= 0 && m < fm[f]) begin
                int lo = (frst[f] >= 0 && m >= frst[f]) ? frst[f] : 0;
                return W'(seg_sum(f, lo, m, r, c));
            end
        end
        return W'(32'hB5A3 ^ (t*37) ^ (r*K + c));
    endfunction

    task automatic chk(string tag, longint act, longint exp, int t);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s cycle %0d: actual=%0d expected=%0d", tag, t, act, exp);
        end
    endtask

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int  erow = 0;
        bit  pev  = 0;
        // R9: reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R9 valid in reset", vld, 0, -1);
        chk("R9 row in reset", ridx, 0, -1);
        chk("R9 data in reset", (rdat == '0) ? 0 : 1, 0, -1);
        rst_n = 1'b1;

        for (int t = 0; t < TEND; t++) begin
            bit ev;
            @(posedge clk);
            #1;
            busy = busy_at(t);
            for (int r = 0; r < K; r++)
                for (int c = 0; c < K; c++)
                    pe_bus[(r*K+c)*W +: W] = pe_val(r, c, t);
            pe_hist[t] = pe_bus;
            @(negedge clk);

            ev   = (t >= DLY) ? busy_at(t - DLY) : 1'b0;
            erow = ev ? (pev ? ((erow == K-1) ? 0 : erow + 1) : 0) : 0;
            pev  = ev;

            if (t == 0) chk("R9 valid after release", vld, 0, t);
            chk((t >= 100 + DLY && t <= 112 + DLY) ? "R8 valid" : "R1 valid", vld, ev, t);
            if (ev) begin
                chk((t >= 100 + DLY && t <= 112 + DLY) ? "R8 row" :
                    (t >= 30 + DLY && t < 50 + DLY) ? "R5 row" : "R3 row", ridx, erow, t);
                for (int c = 0; c < K; c++)
                    chk("R4 column sample", rdat[c*W +: W],
                        pe_hist[t-(K-1-c)][(erow*K+c)*W +: W], t);
                // frame contents against direct matrix sums
                for (int f = 0; f < NF; f++) begin
                    int e = t - fs[f] - DLY;
                    if (e >= 0 && e < fm[f] && (e/K + 1)*K <= fm[f]) begin
                        int fr = e/K + 1;
                        int r  = e % K;
                        int hi = fr*K - 1;
                        int lo = (frst[f] >= 0 && hi >= frst[f]) ? frst[f] : 0;
                        for (int c = 0; c < K; c++)
                            chk((f == 1) ? "R5 frame sum" : (f == 2) ? "R7 frame sum" : "R6 frame sum",
                                rdat[c*W +: W], W'(seg_sum(f, lo, hi, r, c)), t);
                    end
                end
            end else begin
                chk("R2 idle row", ridx, 0, t);
                for (int c = 0; c < K; c++)
                    chk("R2 idle data", rdat[c*W +: W], 0, t);
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule